// File: doc/BRIEF.md
# I/O Bus Device Flag Controller

This block sits on the device side of a 16-bit word-oriented I/O bus. Each cycle the processor may present an I/O instruction word together with a strobe. The block compares the instruction's 6-bit device code with its own configured address and ignores every instruction for any other device. When the codes match, the block carries out the instruction.

A matching instruction moves a word between the processor's accumulator bus and one of three 16-bit data buffers. In the same cycle, the block applies a control action to its two status flags, busy and done. A separate skip form tests one of the two flags in either polarity and answers at once on a skip line.

On the device side, a completion input ends a running operation. It clears busy and sets done, and an interrupt request follows done. The accumulator index from the instruction is passed through so that the processor can steer the transferred word.

Top module: `pdev_flag_ctrl`

## Requirements
- R1: The block acts only on strobed instructions whose bits 5..0 equal the parameter DEV_ADDR. With any other code (including octal 77, which is reserved for the processor and is never a legal DEV_ADDR) it drives no read data, no skip and no pulse, and its buffers and flags keep their values.
- R2: The transfer field sits in bits 10..8. The codes 010, 100 and 110 write bus_wdata into buffer A, B or C respectively at the clock edge that samples the strobe. The other buffers keep their contents.
- R3: The codes 001, 011 and 101 drive buffer A, B or C onto bus_rdata, with bus_rvalid high, in the same cycle as the strobe. At all other times bus_rdata is zero and bus_rvalid is low.
- R4: For a non-skip transfer code, a control field (bits 7..6) of 01 sets busy and clears done at the next edge.
- R5: Control 10 clears both busy and done at the next edge.
- R6: Control 11 raises dev_pulse for the strobe cycle only and leaves both flags unchanged. Control 00 changes no flag.
- R7: Transfer code 111 is a skip test that applies no control action. The bits 7..6 select the condition: 00 busy set, 01 busy clear, 10 done set, 11 done clear. The skip output is high in the strobe cycle exactly when the condition holds.
- R8: dev_complete while busy is set clears busy and sets done at the next edge. dev_complete while busy is clear has no effect.
- R9: When a start or clear action and dev_complete arrive in the same cycle, the control action sets the resulting flag values.
- R10: irq is high exactly while done is set.
- R11: On a matching strobe, acc_sel shows instruction bits 12..11. At other times acc_sel is zero.
- R12: A synchronous reset clears busy, done and all three buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_strobe | input | 1 | Instruction word valid this cycle |
| io_instr | input | 16 | I/O instruction word |
| bus_wdata | input | 16 | Accumulator data for output transfers |
| dev_complete | input | 1 | Device signals end of operation |
| bus_rdata | output | 16 | Buffer data for input transfers, zero otherwise |
| bus_rvalid | output | 1 | bus_rdata carries a buffer word |
| acc_sel | output | 2 | Accumulator index passed through |
| skip | output | 1 | Skip condition holds |
| dev_pulse | output | 1 | Device-specific pulse |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag state appears on busy, done and irq one edge after the instruction or completion that caused it. It also changes the skip answer in the very next test cycle. A corrupted buffer cannot be seen until that buffer is read back, so the bench keeps reading each buffer often, and every stored word is compared within a few dozen cycles of being written. A decode fault shows up in the strobe cycle itself, as data, skip or a pulse appearing for a foreign device code or missing for the block's own code.

// File: rtl/pdev_pkg.sv
`timescale 1ns/1ps
package pdev_pkg;
    localparam int INSTR_W  = 16;
    localparam int CODE_W   = 6;
    localparam int ACC_LSB  = 11;
    localparam int XFER_LSB = 8;
    localparam int CTRL_LSB = 6;

    typedef enum logic [2:0] {
        XF_NONE  = 3'b000,
        XF_IN_A  = 3'b001,
        XF_OUT_A = 3'b010,
        XF_IN_B  = 3'b011,
        XF_OUT_B = 3'b100,
        XF_IN_C  = 3'b101,
        XF_OUT_C = 3'b110,
        XF_SKIP  = 3'b111
    } xfer_e;

    typedef enum logic [1:0] {
        CT_NONE  = 2'b00,
        CT_START = 2'b01,
        CT_CLEAR = 2'b10,
        CT_PULSE = 2'b11
    } ctrl_e;

    typedef enum logic [1:0] {
        SK_BUSY_SET = 2'b00,
        SK_BUSY_CLR = 2'b01,
        SK_DONE_SET = 2'b10,
        SK_DONE_CLR = 2'b11
    } skcond_e;

    typedef struct packed {
        logic busy;
        logic done;
    } flags_t;
endpackage

// File: rtl/pdev_decode.sv
`timescale 1ns/1ps
module pdev_decode
    import pdev_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_ADDR = 6'o12
) (
    input  logic               io_strobe,
    input  logic [INSTR_W-1:0] io_instr,
    output logic               hit,
    output logic [1:0]         acc,
    output logic               rd_en,
    output logic               wr_en,
    output logic [1:0]         buf_idx,
    output logic               test_en,
    output skcond_e            cond,
    output ctrl_e              act
);
    xfer_e      xfer;
    ctrl_e      ctrl;
    logic [2:0] xm1;

    always_comb begin
        hit     = io_strobe && (io_instr[CODE_W-1:0] == DEV_ADDR);
        xfer    = xfer_e'(io_instr[XFER_LSB +: 3]);
        ctrl    = ctrl_e'(io_instr[CTRL_LSB +: 2]);
        cond    = skcond_e'(io_instr[CTRL_LSB +: 2]);
        acc     = hit ? io_instr[ACC_LSB +: 2] : 2'b00;
        xm1     = io_instr[XFER_LSB +: 3] - 3'd1;
        buf_idx = xm1[2:1];
        rd_en   = hit && (xfer inside {XF_IN_A, XF_IN_B, XF_IN_C});
        wr_en   = hit && (xfer inside {XF_OUT_A, XF_OUT_B, XF_OUT_C});
        test_en = hit && (xfer == XF_SKIP);
        act     = (hit && xfer != XF_SKIP) ? ctrl : CT_NONE;
    end
endmodule

// File: rtl/pdev_flags.sv
`timescale 1ns/1ps
module pdev_flags
    import pdev_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctrl_e   act,
    input  logic    complete,
    input  logic    test_en,
    input  skcond_e cond,
    output logic    busy,
    output logic    done,
    output logic    skip,
    output logic    pulse
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (complete && fl_q.busy) begin
            fl_d.busy = 1'b0;
            fl_d.done = 1'b1;
        end
        case (act)
            CT_START: begin fl_d.busy = 1'b1; fl_d.done = 1'b0; end
            CT_CLEAR: begin fl_d.busy = 1'b0; fl_d.done = 1'b0; end
            default:  ;
        endcase
        if (rst) fl_d = '0;

        case (cond)
            SK_BUSY_SET: skip = test_en &&  fl_q.busy;
            SK_BUSY_CLR: skip = test_en && !fl_q.busy;
            SK_DONE_SET: skip = test_en &&  fl_q.done;
            default:     skip = test_en && !fl_q.done;
        endcase
        pulse = (act == CT_PULSE);
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign busy = fl_q.busy;
    assign done = fl_q.done;
endmodule

// File: rtl/pdev_bufs.sv
`timescale 1ns/1ps
module pdev_bufs #(
    parameter int DATA_W  = 16,
    parameter int NUM_BUF = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bank [NUM_BUF];

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_cell
        logic [DATA_W-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && idx == 2'(g)) cell_d = wdata;
            if (rst) cell_d = '0;
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign bank[g] = cell_q;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_BUF; k++) begin
            if (rd_en && idx == 2'(k)) rdata = bank[k];
        end
    end
endmodule

// File: rtl/pdev_flag_ctrl.sv
`timescale 1ns/1ps
module pdev_flag_ctrl
    import pdev_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_ADDR = 6'o12,
    parameter int                DATA_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_strobe,
    input  logic [INSTR_W-1:0] io_instr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               dev_complete,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic [1:0]         acc_sel,
    output logic               skip,
    output logic               dev_pulse,
    output logic               busy,
    output logic               done,
    output logic               irq
);
    localparam int NUM_BUF = 3;

    logic       hit, rd_en, wr_en, test_en;
    logic [1:0] buf_idx;
    skcond_e    cond;
    ctrl_e      act;

    pdev_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .io_strobe (io_strobe),
        .io_instr  (io_instr),
        .hit       (hit),
        .acc       (acc_sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .buf_idx   (buf_idx),
        .test_en   (test_en),
        .cond      (cond),
        .act       (act)
    );

    pdev_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .complete (dev_complete),
        .test_en  (test_en),
        .cond     (cond),
        .busy     (busy),
        .done     (done),
        .skip     (skip),
        .pulse    (dev_pulse)
    );

    pdev_bufs #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF)) u_bufs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .idx   (buf_idx),
        .wdata (bus_wdata),
        .rdata (bus_rdata)
    );

    assign bus_rvalid = rd_en;
    assign irq        = done;
endmodule

// File: rtl/pdev_checker.sv
`timescale 1ns/1ps
module pdev_checker #(
    parameter logic [5:0] DEV_ADDR = 6'o12,
    parameter int         DATA_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              io_strobe,
    input logic [15:0]       io_instr,
    input logic              dev_complete,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              skip,
    input logic              dev_pulse,
    input logic              busy,
    input logic              done,
    input logic              irq
);
    logic       mine, ctl;
    logic [2:0] xf;
    logic [1:0] ct;

    assign mine = io_strobe && (io_instr[5:0] == DEV_ADDR);
    assign xf   = io_instr[10:8];
    assign ct   = io_instr[7:6];
    assign ctl  = mine && (xf != 3'b111);

    initial begin
        a_r1_addr_legal: assert (DEV_ADDR != 6'o77);
    end

    a_r1_silent: assert property (@(posedge clk) disable iff (rst)
        !mine |-> (!bus_rvalid && bus_rdata == '0 && !skip && !dev_pulse));

    a_r1_flags_kept: assert property (@(posedge clk) disable iff (rst)
        (!mine && !dev_complete) |=> ($stable(busy) && $stable(done)));

    a_r3_drive: assert property (@(posedge clk) disable iff (rst)
        (mine && xf inside {3'b001, 3'b011, 3'b101}) |-> bus_rvalid);

    a_r4_start: assert property (@(posedge clk) disable iff (rst)
        (ctl && ct == 2'b01) |=> (busy && !done));

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl && ct == 2'b10) |=> (!busy && !done));

    a_r6_pulse_keeps: assert property (@(posedge clk) disable iff (rst)
        (ctl && ct == 2'b11 && !dev_complete) |=> ($stable(busy) && $stable(done)));

    a_r8_finish: assert property (@(posedge clk) disable iff (rst)
        (busy && dev_complete && !(ctl && ct inside {2'b01, 2'b10})) |=> (!busy && done));

    a_r10_irq: assert property (@(posedge clk) disable iff (rst)
        irq == done);

    a_r12_reset: assert property (@(posedge clk)
        rst |=> (!busy && !done));
endmodule

bind pdev_flag_ctrl pdev_checker #(.DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .io_strobe    (io_strobe),
    .io_instr     (io_instr),
    .dev_complete (dev_complete),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .skip         (skip),
    .dev_pulse    (dev_pulse),
    .busy         (busy),
    .done         (done),
    .irq          (irq)
);

// File: tb/test_pdev_flag_ctrl.sv
`timescale 1ns/1ps
module test_pdev_flag_ctrl;
    localparam logic [5:0] MY = 6'o12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_strobe = 1'b0;
    logic [15:0] io_instr = '0;
    logic [15:0] bus_wdata = '0;
    logic        dev_complete = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid, skip, dev_pulse, busy, done, irq;
    logic [1:0]  acc_sel;

    int n_cmp = 0;
    int n_bad = 0;

    logic        m_busy, m_done;
    logic [15:0] m_buf [3];
    string       ftag;

    always #10 clk = ~clk;

    pdev_flag_ctrl #(.DEV_ADDR(MY), .DATA_W(16)) i_pdev_flag_ctrl (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_instr(io_instr),
        .bus_wdata(bus_wdata), .dev_complete(dev_complete),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .acc_sel(acc_sel),
        .skip(skip), .dev_pulse(dev_pulse), .busy(busy), .done(done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] a, input logic [2:0] x,
                                       input logic [1:0] c, input logic [5:0] code);
        return {3'b011, a, x, c, code};
    endfunction

    function automatic logic exp_skip(input logic [1:0] c, input logic b, input logic d);
        case (c)
            2'b00:   return b;
            2'b01:   return !b;
            2'b10:   return d;
            default: return !d;
        endcase
    endfunction

    // one bus cycle: drive, check outputs, advance the model
    task automatic step(input logic r, input logic st, input logic [15:0] ins,
                        input logic [15:0] wd, input logic cp);
        logic       hit, isrd, iswr, istest;
        logic [2:0] x;
        logic [1:0] c, idx;
        @(negedge clk);
        rst = r; io_strobe = st; io_instr = ins; bus_wdata = wd; dev_complete = cp;
        #1;
        check({ftag, " busy"}, busy, m_busy);
        check({ftag, " done"}, done, m_done);
        check("R10 irq", irq, m_done);
        x      = ins[10:8];
        c      = ins[7:6];
        hit    = st && ins[5:0] == MY;
        isrd   = hit && x inside {3'b001, 3'b011, 3'b101};
        iswr   = hit && x inside {3'b010, 3'b100, 3'b110};
        istest = hit && x == 3'b111;
        idx    = 2'((x - 3'd1) >> 1);
        check("R1/R3 rvalid", bus_rvalid, isrd);
        check("R2/R3 rdata", bus_rdata, isrd ? m_buf[idx] : 16'h0);
        check("R7 skip", skip, istest && exp_skip(c, m_busy, m_done));
        check("R6 pulse", dev_pulse, hit && !istest && c == 2'b11);
        check("R11 acc", acc_sel, hit ? ins[12:11] : 2'b00);
        // next state
        ftag = "R1";
        if (cp && m_busy) begin m_busy = 1'b0; m_done = 1'b1; ftag = "R8"; end
        if (hit && !istest && c == 2'b01) begin
            m_busy = 1'b1; m_done = 1'b0; ftag = cp ? "R9" : "R4";
        end
        if (hit && !istest && c == 2'b10) begin
            m_busy = 1'b0; m_done = 1'b0; ftag = cp ? "R9" : "R5";
        end
        if (iswr) m_buf[idx] = wd;
        if (r) begin
            m_busy = 1'b0; m_done = 1'b0; ftag = "R12";
            for (int k = 0; k < 3; k++) m_buf[k] = '0;
        end
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_busy = 1'b0; m_done = 1'b0; ftag = "R12";
        for (int k = 0; k < 3; k++) m_buf[k] = '0;
        // R12 reset, then read each buffer to see zeros
        step(1, 0, '0, '0, 0);
        step(1, 0, '0, '0, 0);
        step(0, 1, mk(2'd0, 3'b001, 2'b00, MY), '0, 0);
        step(0, 1, mk(2'd1, 3'b011, 2'b00, MY), '0, 0);
        step(0, 1, mk(2'd2, 3'b101, 2'b00, MY), '0, 0);
        // R2 writes with R4 start, R3 readback
        step(0, 1, mk(2'd3, 3'b010, 2'b01, MY), 16'hA5A5, 0);
        step(0, 1, mk(2'd0, 3'b100, 2'b00, MY), 16'h1234, 0);
        step(0, 1, mk(2'd1, 3'b110, 2'b11, MY), 16'hFFFF, 0);
        step(0, 1, mk(2'd2, 3'b001, 2'b00, MY), '0, 0);
        step(0, 1, mk(2'd3, 3'b011, 2'b00, MY), '0, 0);
        step(0, 1, mk(2'd0, 3'b101, 2'b00, MY), '0, 0);
        // R7 all conditions while busy
        for (int c = 0; c < 4; c++) step(0, 1, mk(2'd0, 3'b111, 2'(c), MY), '0, 0);
        // R1 foreign codes incl. 77 try to clear and write
        step(0, 1, mk(2'd0, 3'b010, 2'b10, 6'o77), 16'hDEAD, 0);
        step(0, 1, mk(2'd0, 3'b001, 2'b10, 6'o13), '0, 0);
        // R8 completion, then all conditions while done
        step(0, 0, '0, '0, 1);
        for (int c = 0; c < 4; c++) step(0, 1, mk(2'd1, 3'b111, 2'(c), MY), '0, 0);
        // R8 completion while idle is ignored
        step(0, 1, mk(2'd0, 3'b000, 2'b10, MY), '0, 0);
        step(0, 0, '0, '0, 1);
        step(0, 0, '0, '0, 0);
        // R9 start with completion, clear with completion
        step(0, 1, mk(2'd0, 3'b000, 2'b01, MY), '0, 0);
        step(0, 1, mk(2'd0, 3'b000, 2'b01, MY), '0, 1);
        step(0, 1, mk(2'd0, 3'b000, 2'b10, MY), '0, 1);
        step(0, 0, '0, '0, 0);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  code;
            logic [15:0] ins;
            code = ($urandom % 10 < 7) ? MY : 6'($urandom);
            ins  = mk(2'($urandom), 3'($urandom), 2'($urandom), code);
            step(($urandom % 400) == 0, ($urandom % 10) < 7, ins, 16'($urandom),
                 ($urandom % 10) < 3);
        end
        step(0, 0, '0, '0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule